// File: doc/BRIEF.md
# Addressable Variable-Length Delay Line

This block delays a multi-bit word stream by a number of clock cycles. In fixed mode the delay is a build-time constant. In variable mode the delay is read every cycle from an address input. The words sit in a shift storage that has no reset, and a tap multiplexer picks the word that leaves the block. The address can change at any time without losing valid output, because each tap always holds a word that really entered the line that many cycles before.

The multiplexer output can pass through one or two pipeline stages, which trade latency for timing. A final output register can also be enabled. That register is the only state that clear, set, initialize and the power-up value act on. A clock enable freezes the whole line at once. Parameters choose how the controls rank against each other and whether the clock enable gates them.

Top module: `addressable_delay_line`

## Requirements
- R1: In fixed mode (VARIABLE=0), a word presented on `din_i` appears on `dout_o` exactly DEPTH enabled cycles later. The final output register, when present, is one of those DEPTH cycles.
- R2: In variable mode, address k (0 to DEPTH-1) gives a storage delay of k+1 enabled cycles. Any address above DEPTH-1 behaves as DEPTH-1.
- R3: When the address changes, the next output is the word already held at the newly chosen tap. No invalid or stale word is produced.
- R4: In variable mode, enabling the output register (OUT_REG=1) adds exactly one cycle to the addressed delay.
- R5: With SPEED=1 in variable mode, the tap output is registered for one extra cycle. When DEPTH is above 256, the multiplexer is split into two registered levels, for two extra cycles.
- R6: While the effective clock enable is low, the storage, the pipeline stages and the output register all hold their values.
- R7: An active clear drives the output register to all zeros, and an active set drives it to all ones. When both are active, CLR_WINS=1 (the default) makes clear win and CLR_WINS=0 makes set win.
- R8: With SYNC_OVER_CE=1, clear, set and initialize act whatever the state of `ce_i`. With SYNC_OVER_CE=0, they act only in cycles where `ce_i` is high. If the enable is absent, they always act.
- R9: An active initialize loads INIT_VAL into the output register at the next edge. Initialize takes priority over clear and set. A build that enables initialize together with set or clear is rejected at elaboration.
- R10: While `rst_ni` is low, the output register takes POWERUP_VAL.
- R11: Clear, set and initialize never alter the storage or the pipeline stages. After the controls are released, the delayed stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low power-up load of the output register only |
| ce_i | input | 1 | Clock enable for the whole line (used when HAS_CE=1) |
| sclr_i | input | 1 | Synchronous clear of the output register |
| sset_i | input | 1 | Synchronous set of the output register |
| sinit_i | input | 1 | Synchronous load of INIT_VAL into the output register |
| addr_i | input | $clog2(DEPTH)+1 | Tap select; values above DEPTH-1 saturate |
| din_i | input | WIDTH | Data word in |
| dout_o | output | WIDTH | Delayed data word out |

## Verification
The bench attacks address changes on every cycle, including out-of-range addresses. A block that latched the address late, or wrapped instead of saturating, would emit words from the wrong age. It also drives long random enable patterns against four builds (fixed, plain variable, single-stage speed, and two-level speed with DEPTH 300), where a pipeline stage that kept running while the rest stalled would skew the output by a cycle. Clear, set and initialize are pulsed with the enable both high and low. This exposes a wrong priority, a wrong enable qualification, or any control that leaked into the storage and damaged the stream that follows.

// File: rtl/dl_pkg.sv
package dl_pkg;

    localparam int GROUP_WORDS = 256;

    typedef enum logic [2:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_ZERO,
        ACT_ONES,
        ACT_INIT
    } out_act_e;

    function automatic int pipe_stages(bit speed, bit variable, int depth);
        if (!speed || !variable) return 0;
        return (depth > GROUP_WORDS) ? 2 : 1;
    endfunction

endpackage

// File: rtl/dl_shift_store.sv
module dl_shift_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 12
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         en_i,
    input  logic [WIDTH-1:0]             din_i,
    output logic [DEPTH-1:0][WIDTH-1:0]  words_o
);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] words;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (en_i) begin
            s_d.words[0] = din_i;
            for (int i = 1; i < DEPTH; i++) begin
                s_d.words[i] = s_q.words[i-1];
            end
        end
    end

    // storage is deliberately not resettable
    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign words_o = s_q.words;

    a_r6_store_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(words_o));

    a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> words_o[0] == $past(din_i));

endmodule

// File: rtl/dl_tap_select.sv
module dl_tap_select #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 12,
    parameter int PIPE  = 0,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         en_i,
    input  logic [DEPTH-1:0][WIDTH-1:0]  words_i,
    input  logic [IDX_W-1:0]             sel_i,
    output logic [WIDTH-1:0]             tap_o
);

    if (PIPE == 0) begin : g_comb
        logic unused_pipe0;
        assign unused_pipe0 = ^{clk_i, rst_ni, en_i};
        assign tap_o = words_i[sel_i];
    end else if (PIPE == 1) begin : g_one
        typedef struct packed {
            logic [WIDTH-1:0] tap;
        } p1_t;
        p1_t p_d, p_q;

        always_comb begin
            p_d = p_q;
            if (en_i) p_d.tap = words_i[sel_i];
        end

        always_ff @(posedge clk_i) begin
            p_q <= p_d;
        end

        assign tap_o = p_q.tap;

        a_r5_stage_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i |=> $stable(tap_o));
    end else begin : g_two
        localparam int NG   = (DEPTH + dl_pkg::GROUP_WORDS - 1) / dl_pkg::GROUP_WORDS;
        localparam int HI_W = (NG > 1) ? $clog2(NG) : 1;

        typedef struct packed {
            logic [NG-1:0][WIDTH-1:0] grp;
            logic [HI_W-1:0]          hi;
            logic [WIDTH-1:0]         tap;
        } p2_t;
        p2_t p_d, p_q;

        always_comb begin
            p_d = p_q;
            if (en_i) begin
                for (int g = 0; g < NG; g++) begin
                    int idx;
                    idx = g * dl_pkg::GROUP_WORDS + (int'(sel_i) % dl_pkg::GROUP_WORDS);
                    p_d.grp[g] = (idx < DEPTH) ? words_i[IDX_W'(idx)] : '0;
                end
                p_d.hi  = HI_W'(int'(sel_i) / dl_pkg::GROUP_WORDS);
                p_d.tap = p_q.grp[p_q.hi];
            end
        end

        always_ff @(posedge clk_i) begin
            p_q <= p_d;
        end

        assign tap_o = p_q.tap;

        a_r5_level_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i |=> $stable(tap_o) && $stable(p_q.hi));
    end

endmodule

// File: rtl/dl_out_stage.sv
module dl_out_stage #(
    parameter int               WIDTH        = 8,
    parameter bit               HAS_SCLR     = 1,
    parameter bit               HAS_SSET     = 1,
    parameter bit               HAS_SINIT    = 0,
    parameter bit               CLR_WINS     = 1,
    parameter bit               SYNC_OVER_CE = 1,
    parameter logic [WIDTH-1:0] INIT_VAL     = '0,
    parameter logic [WIDTH-1:0] POWERUP_VAL  = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             set_i,
    input  logic             init_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    import dl_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] q;
    } out_t;

    out_t      o_d, o_q;
    out_act_e  act;
    logic      ctl_ok, clr_a, set_a, init_a;

    always_comb begin
        ctl_ok = SYNC_OVER_CE || en_i;
        clr_a  = HAS_SCLR  && clr_i  && ctl_ok;
        set_a  = HAS_SSET  && set_i  && ctl_ok;
        init_a = HAS_SINIT && init_i && ctl_ok;

        if (init_a)                 act = ACT_INIT;
        else if (clr_a && set_a)    act = CLR_WINS ? ACT_ZERO : ACT_ONES;
        else if (clr_a)             act = ACT_ZERO;
        else if (set_a)             act = ACT_ONES;
        else if (en_i)              act = ACT_LOAD;
        else                        act = ACT_HOLD;

        o_d = o_q;
        unique case (act)
            ACT_INIT: o_d.q = INIT_VAL;
            ACT_ZERO: o_d.q = '0;
            ACT_ONES: o_d.q = '1;
            ACT_LOAD: o_d.q = d_i;
            default:  o_d.q = o_q.q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) o_q.q <= POWERUP_VAL;
        else         o_q   <= o_d;
    end

    assign q_o = o_q.q;

    a_r10_powerup: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> q_o == POWERUP_VAL);

    a_r6_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !clr_i && !set_i && !init_i) |=> $stable(q_o));

    if (HAS_SCLR) begin : g_clr_chk
        a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i && (SYNC_OVER_CE || en_i) && (CLR_WINS || !(HAS_SSET && set_i)))
            |=> q_o == '0);
    end

    if (HAS_SSET) begin : g_set_chk
        a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (set_i && (SYNC_OVER_CE || en_i) && (!CLR_WINS || !(HAS_SCLR && clr_i)))
            |=> q_o == '1);
    end

    if (HAS_SINIT) begin : g_init_chk
        a_r9_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (init_i && (SYNC_OVER_CE || en_i)) |=> q_o == INIT_VAL);
    end

    if (!SYNC_OVER_CE) begin : g_gate_chk
        a_r8_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i |=> $stable(q_o));
    end

endmodule

// File: rtl/addressable_delay_line.sv
module addressable_delay_line #(
    parameter int               WIDTH        = 8,
    parameter int               DEPTH        = 12,
    parameter bit               VARIABLE     = 1,
    parameter bit               OUT_REG      = 1,
    parameter bit               SPEED        = 0,
    parameter bit               HAS_CE       = 1,
    parameter bit               HAS_SCLR     = 1,
    parameter bit               HAS_SSET     = 1,
    parameter bit               HAS_SINIT    = 0,
    parameter bit               CLR_WINS     = 1,
    parameter bit               SYNC_OVER_CE = 1,
    parameter logic [WIDTH-1:0] INIT_VAL     = '0,
    parameter logic [WIDTH-1:0] POWERUP_VAL  = '0,
    localparam int              IDX_W        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int              ADDR_W       = IDX_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ce_i,
    input  logic              sclr_i,
    input  logic              sset_i,
    input  logic              sinit_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  din_i,
    output logic [WIDTH-1:0]  dout_o
);

    localparam int PIPE    = dl_pkg::pipe_stages(SPEED, VARIABLE, DEPTH);
    localparam int FIX_TAP = DEPTH - 1 - int'(OUT_REG);

    if (HAS_SINIT && (HAS_SCLR || HAS_SSET)) begin : g_bad_ctl
        $error("initialize cannot be combined with set or clear");
    end
    if (DEPTH < 2) begin : g_bad_depth
        $error("DEPTH must be at least 2");
    end

    logic                        en;
    logic [IDX_W-1:0]            sel;
    logic [DEPTH-1:0][WIDTH-1:0] words;
    logic [WIDTH-1:0]            tap;
    logic                        unused_ports;

    assign unused_ports = ^{ce_i, sclr_i, sset_i, sinit_i, addr_i};

    always_comb begin
        en = HAS_CE ? ce_i : 1'b1;
        if (!VARIABLE)                               sel = IDX_W'(FIX_TAP);
        else if (addr_i > ADDR_W'(DEPTH - 1))        sel = IDX_W'(DEPTH - 1);
        else                                         sel = addr_i[IDX_W-1:0];
    end

    dl_shift_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en),
        .din_i   (din_i),
        .words_o (words)
    );

    dl_tap_select #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PIPE(PIPE)) u_select (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en),
        .words_i (words),
        .sel_i   (sel),
        .tap_o   (tap)
    );

    if (OUT_REG) begin : g_oreg
        dl_out_stage #(
            .WIDTH(WIDTH), .HAS_SCLR(HAS_SCLR), .HAS_SSET(HAS_SSET),
            .HAS_SINIT(HAS_SINIT), .CLR_WINS(CLR_WINS),
            .SYNC_OVER_CE(SYNC_OVER_CE), .INIT_VAL(INIT_VAL),
            .POWERUP_VAL(POWERUP_VAL)
        ) u_out (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (en),
            .clr_i  (sclr_i),
            .set_i  (sset_i),
            .init_i (sinit_i),
            .d_i    (tap),
            .q_o    (dout_o)
        );

        a_r4_reg_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en && !sclr_i && !sset_i && !sinit_i) |=> dout_o == $past(tap));
    end else begin : g_noreg
        assign dout_o = tap;
    end

endmodule

// File: tb/addressable_delay_line_tb_top.sv
module dl_model #(
    parameter int       W = 8, DEPTH = 12,
    parameter bit       VARIABLE = 1, OUT_REG = 1,
    parameter int       PIPE = 0,
    parameter bit       HAS_CE = 1, HAS_SCLR = 0, HAS_SSET = 0, HAS_SINIT = 0,
    parameter bit       CLR_WINS = 1, SYNC_OVER_CE = 1,
    parameter logic [W-1:0] INIT_VAL = '0, POWERUP_VAL = '0
) (
    input  logic         clk, rst_n, ce, clr, set, init,
    input  int           addr,
    input  logic [W-1:0] din,
    output logic [W-1:0] exp_o,
    output bit           known_o
);
    logic [W-1:0] hist[$];
    logic [W-1:0] pv[2];
    bit           pk[2];
    logic [W-1:0] q;
    bit           qk;

    function automatic int tap_idx(int a);
        if (!VARIABLE) return DEPTH - 1 - int'(OUT_REG);
        return (a > DEPTH - 1) ? DEPTH - 1 : a;
    endfunction

    always @(posedge clk) begin
        bit en, ok, tk, pok;
        int idx;
        logic [W-1:0] tv, pov;
        if (!rst_n) begin
            q = POWERUP_VAL; qk = 1; pk[0] = 0; pk[1] = 0;
        end else begin
            en  = HAS_CE ? ce : 1'b1;
            idx = tap_idx(addr);
            tk  = idx < hist.size();
            tv  = tk ? hist[idx] : '0;
            if (PIPE == 0) begin pov = tv; pok = tk; end
            else begin pov = pv[(PIPE > 0) ? PIPE-1 : 0]; pok = pk[(PIPE > 0) ? PIPE-1 : 0]; end
            if (OUT_REG) begin
                ok = SYNC_OVER_CE || en;
                if (HAS_SINIT && init && ok) begin q = INIT_VAL; qk = 1; end
                else if (HAS_SCLR && clr && ok && (CLR_WINS || !(HAS_SSET && set))) begin q = '0; qk = 1; end
                else if (HAS_SSET && set && ok) begin q = '1; qk = 1; end
                else if (en) begin q = pov; qk = pok; end
            end
            if (en) begin
                pv[1] = pv[0]; pk[1] = pk[0];
                pv[0] = tv;    pk[0] = tk;
                hist.push_front(din);
                if (hist.size() > DEPTH) void'(hist.pop_back());
            end
        end
    end

    always @(negedge clk) begin
        int idx;
        #1;
        if (OUT_REG) begin exp_o = q; known_o = qk; end
        else if (PIPE > 0) begin
            exp_o = pv[(PIPE > 0) ? PIPE-1 : 0]; known_o = pk[(PIPE > 0) ? PIPE-1 : 0];
        end else begin
            idx = tap_idx(addr);
            known_o = idx < hist.size();
            exp_o = known_o ? hist[idx] : '0;
        end
    end
endmodule

module addressable_delay_line_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0, ce = 0, clr = 0, set = 0, init = 0;
    logic [4:0] addr_s = '0;
    logic [9:0] addr_l = '0;
    logic [7:0] din = '0;
    logic [7:0] dout_a, dout_b, dout_c, dout_d, ea, eb, ec, ed;
    bit ka, kb, kc, kd;
    string phase = "R10";
    int compared = 0, mismatched = 0;
    bit running = 0, done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // variable, output register, clear/set, clear wins, controls override enable
    addressable_delay_line #(.DEPTH(12), .POWERUP_VAL(8'hA5)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclr_i(clr), .sset_i(set),
        .sinit_i(init), .addr_i(addr_s), .din_i(din), .dout_o(dout_a));
    dl_model #(.DEPTH(12), .HAS_SCLR(1), .HAS_SSET(1), .POWERUP_VAL(8'hA5)) ref_a (
        .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .set(set), .init(init),
        .addr(int'(addr_s)), .din(din), .exp_o(ea), .known_o(ka));

    // deep, two-level speed pipeline, initialize, controls gated by enable
    addressable_delay_line #(.DEPTH(300), .SPEED(1), .HAS_SCLR(0), .HAS_SSET(0),
        .HAS_SINIT(1), .SYNC_OVER_CE(0), .INIT_VAL(8'h3C), .POWERUP_VAL(8'h5A)) dut_spd_i (
        .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclr_i(clr), .sset_i(set),
        .sinit_i(init), .addr_i(addr_l), .din_i(din), .dout_o(dout_b));
    dl_model #(.DEPTH(300), .PIPE(2), .HAS_SINIT(1), .SYNC_OVER_CE(0),
        .INIT_VAL(8'h3C), .POWERUP_VAL(8'h5A)) ref_b (
        .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .set(set), .init(init),
        .addr(int'(addr_l)), .din(din), .exp_o(eb), .known_o(kb));

    // fixed length with output register, set wins
    addressable_delay_line #(.DEPTH(12), .VARIABLE(0), .CLR_WINS(0), .POWERUP_VAL(8'hC3)) dut_fix_i (
        .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclr_i(clr), .sset_i(set),
        .sinit_i(init), .addr_i(addr_s), .din_i(din), .dout_o(dout_c));
    dl_model #(.DEPTH(12), .VARIABLE(0), .HAS_SCLR(1), .HAS_SSET(1), .CLR_WINS(0),
        .POWERUP_VAL(8'hC3)) ref_c (
        .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .set(set), .init(init),
        .addr(int'(addr_s)), .din(din), .exp_o(ec), .known_o(kc));

    // variable, single speed stage, no output register
    addressable_delay_line #(.DEPTH(12), .OUT_REG(0), .SPEED(1)) dut_one_i (
        .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclr_i(clr), .sset_i(set),
        .sinit_i(init), .addr_i(addr_s), .din_i(din), .dout_o(dout_d));
    dl_model #(.DEPTH(12), .OUT_REG(0), .PIPE(1)) ref_d (
        .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .set(set), .init(init),
        .addr(int'(addr_s)), .din(din), .exp_o(ed), .known_o(kd));

    task automatic chk(string nm, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", phase, nm, act, exp);
        end
    endtask

    always begin
        @(negedge clk);
        #2;
        if (running && rst_n) begin
            if (ka) chk("var_reg", dout_a, ea);
            if (kb) chk("deep_speed", dout_b, eb);
            if (kc) chk("fixed", dout_c, ec);
            if (kd) chk("var_stage", dout_d, ed);
        end
    end

    task automatic steps(int n, int ce_pct, int ctl_pct, bit use_init, int addr_mode);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            din  = 8'($urandom);
            ce   = (($urandom % 100) < ce_pct);
            clr  = (($urandom % 100) < ctl_pct);
            set  = (($urandom % 100) < ctl_pct);
            init = use_init && (($urandom % 100) < ctl_pct);
            if (addr_mode == 1 && (k % 4) == 0) begin
                addr_s = 5'((k / 4) % 16);
                addr_l = 10'((k * 37) % 1024);
            end else if (addr_mode == 2) begin
                addr_s = 5'($urandom);
                addr_l = 10'($urandom);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3;
        phase = "R10";
        chk("powerup_a", dout_a, 8'hA5);
        chk("powerup_b", dout_b, 8'h5A);
        chk("powerup_c", dout_c, 8'hC3);
        @(negedge clk);
        rst_n = 1;
        running = 1;
        addr_s = 5'd3; addr_l = 10'd40;
        phase = "R1";  steps(320, 100, 0, 0, 0);
        phase = "R2";  steps(80, 100, 0, 0, 1);
        phase = "R3";  steps(80, 100, 0, 0, 2);
        addr_s = 5'd7; addr_l = 10'd299;
        phase = "R4";  steps(40, 100, 0, 0, 0);
        addr_s = 5'd0; addr_l = 10'd257;
        phase = "R5";  steps(40, 100, 0, 0, 0);
        phase = "R6";  steps(120, 50, 0, 0, 2);
        phase = "R7";  steps(80, 100, 30, 0, 2);
        phase = "R8";  steps(100, 40, 30, 1, 2);
        phase = "R9";  steps(80, 60, 0, 1, 2);
        // hold every control high, then check the stream survived
        phase = "R11";
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            din = 8'($urandom); ce = 1; clr = 1; set = 1; init = 1;
        end
        steps(60, 100, 0, 0, 2);
        @(negedge clk);
        @(negedge clk);
        running = 0;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog all-requirements actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule